// File: doc/BRIEF.md
# Phase-Aligned Clock-Enable Divider Bank

This block derives several slow enable strobes from one fast clock, so that all logic downstream stays in a single clock domain. It does not generate clocks. Each output is a one-cycle pulse that a register uses as its clock enable. A source divider counts master cycles. Two or more child dividers count the source divider's terminal pulses, which gives chained ratios such as 2 x 5 = one pulse every 10 master cycles.

A shared load strobe preloads every counter on the same master edge. Each counter takes its own phase offset, so the outputs start in a known and fixed phase relationship. An optional resynchronisation stage delays every output by the same number of master cycles. The outputs therefore stay aligned with each other when that stage is on. Divide ratios and phases are runtime inputs. A new ratio is taken only at a period boundary, so a period is never cut short.

Top module: `clken_bank`

## Requirements
- R1: With source ratio R (0 acts as 1) and preload p, a load sampled on edge L gives `src_en` pulses on edges L+R-p, then every R edges. A ratio of 1 pulses on every cycle.
- R2: Child k counts source terminal pulses. With ratio C (0 acts as 1) and preload q, its first pulse falls on the (C-q)-th source pulse after the load, then on every C-th source pulse. Its period is therefore R*C master cycles.
- R3: A phase input larger than ratio-1 is clamped to ratio-1 when it is preloaded.
- R4: Synchronous reset zeroes every counter and ignores the phase inputs. It also latches the ratio inputs and drives all outputs low. No output pulses before its first full period after the last reset edge.
- R5: A load preloads every counter on the same edge. All outputs are low in the cycle after the load, and pulses still in the resynchronisation stages are dropped.
- R6: A change of a ratio input takes effect only at that divider's next terminal count or at a load. The period in progress keeps the old ratio.
- R7: With `resync_on` high, every output is delayed by exactly LAT (default 3) master cycles, and the delay is the same for all outputs.
- R8: Every child pulse coincides with a source pulse.
- R9: When the active ratio is 2 or more and resync is off, each output pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Common restart strobe that preloads all counters |
| resync_on | input | 1 | Adds LAT cycles of latency to every output |
| src_ratio | input | W | Source divide ratio |
| src_phase | input | W | Source counter preload applied on load |
| ch_ratio | input | NCH*W | Child ratios, child k in bits [k*W +: W] |
| ch_phase | input | NCH*W | Child preloads, child k in bits [k*W +: W] |
| src_en | output | 1 | Source enable pulse |
| ch_en | output | NCH | Child enable pulses, bit k for child k |

## Verification
Two functions can meet in one cycle. The first case is a load strobe arriving while terminal pulses are still in flight in the resynchronisation stages. The bench reloads four cycles after a resync segment with ratio 1 and expects those queued pulses to vanish. The second case is a ratio change landing in the period that is already counting. The bench alters the source ratio one cycle after a load and expects the first period to keep the old length and all later periods to use the new one. A scoreboard holds every expected pulse cycle of each output. Both a missing pulse and a pulse at an unexpected cycle count as a failure.

// File: rtl/clken_bank.sv
`timescale 1ns/1ps
module clken_bank #(
  parameter int W   = 8,
  parameter int NCH = 2,
  parameter int LAT = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           resync_on,
  input  logic [W-1:0]   src_ratio,
  input  logic [W-1:0]   src_phase,
  input  logic [NCH*W-1:0] ch_ratio,
  input  logic [NCH*W-1:0] ch_phase,
  output logic           src_en,
  output logic [NCH-1:0] ch_en
);
  localparam int NOUT = NCH + 1;

  logic [NOUT*W-1:0] ratio_all;
  logic [NOUT*W-1:0] phase_all;
  logic [NOUT-1:0]   outs;
  logic              src_tick;

  assign ratio_all = {ch_ratio, src_ratio};
  assign phase_all = {ch_phase, src_phase};

  for (genvar g = 0; g < NOUT; g++) begin : gen_div
    logic [W-1:0]   cnt, lim;
    logic [W-1:0]   rin, ph, last_in, pre;
    logic           step, tick, pulse;
    logic [LAT-1:0] pipe;

    assign rin     = ratio_all[g*W +: W];
    assign ph      = phase_all[g*W +: W];
    assign last_in = (rin == '0) ? '0 : rin - 1'b1;
    assign pre     = (ph > last_in) ? last_in : ph;

    if (g == 0) begin : gen_src
      assign step     = 1'b1;
      assign src_tick = tick;
    end else begin : gen_child
      assign step = src_tick;
    end

    assign tick = step && (cnt == lim) && !load && !rst;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt   <= '0;
        lim   <= last_in;
        pulse <= 1'b0;
      end else if (load) begin
        cnt   <= pre;
        lim   <= last_in;
        pulse <= 1'b0;
      end else begin
        pulse <= tick;
        if (tick) begin
          cnt <= '0;
          lim <= last_in;
        end else if (step) begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst || load) begin
        pipe <= '0;
      end else begin
        pipe[0] <= pulse;
        for (int k = 1; k < LAT; k++) pipe[k] <= pipe[k-1];
      end
    end

    assign outs[g] = resync_on ? pipe[LAT-1] : pulse;

    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (rst)
      cnt <= lim);

    assert_single_cycle_R9: assert property (@(posedge clk) disable iff (rst)
      (outs[g] && !resync_on && lim >= 1) |=> (!outs[g] || resync_on));
  end

  assign src_en = outs[0];
  assign ch_en  = outs[NOUT-1:1];

  assert_reset_quiet_R4: assert property (@(posedge clk)
    rst |=> (!src_en && ch_en == '0));

  assert_load_clears_R5: assert property (@(posedge clk) disable iff (rst)
    load |=> (!src_en && ch_en == '0));

  assert_child_on_source_R8: assert property (@(posedge clk) disable iff (rst)
    (ch_en != '0) |-> src_en);
endmodule

// File: tb/tb_clken_bank.sv
`timescale 1ns/1ps
module tb_clken_bank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic resync_on = 1'b0;
  logic [7:0]  src_ratio = 8'd2;
  logic [7:0]  src_phase = 8'd0;
  logic [15:0] ch_ratio = 16'h0305;
  logic [15:0] ch_phase = 16'h0000;
  logic src_en;
  logic [1:0] ch_en;

  clken_bank #(.W(8), .NCH(2), .LAT(3)) dut (
    .clk(clk), .rst(rst), .load(load), .resync_on(resync_on),
    .src_ratio(src_ratio), .src_phase(src_phase),
    .ch_ratio(ch_ratio), .ch_phase(ch_phase),
    .src_en(src_en), .ch_en(ch_en));

  always #10 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  string tag = "R4";
  int expq[3][$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mon_on) begin
      for (int i = 0; i < 3; i++) begin
        logic p;
        p = (i == 0) ? src_en : ch_en[i-1];
        while (expq[i].size() > 0 && expq[i][0] < cyc) begin
          checks++; errors++;
          $display("FAIL %s out%0d: actual no pulse, expected pulse at cycle %0d", tag, i, expq[i][0]);
          void'(expq[i].pop_front());
        end
        if (p) begin
          checks++;
          if (expq[i].size() > 0 && expq[i][0] == cyc) void'(expq[i].pop_front());
          else begin
            errors++;
            $display("FAIL %s out%0d: actual pulse at cycle %0d, expected next %0d",
                     tag, i, cyc, (expq[i].size() > 0) ? expq[i][0] : -1);
          end
        end
      end
    end
  end

  task automatic plan(int L, int H, int r1, int r2, int ps, int c0, int q0, int c1, int q1, bit rs);
    int a1, a2, p, d, t, j;
    int c[2];
    int q[2];
    int need[2];
    a1 = (r1 < 1) ? 1 : r1;
    a2 = (r2 < 1) ? 1 : r2;
    p  = (ps > a1 - 1) ? a1 - 1 : ps;
    d  = rs ? 3 : 0;
    c[0] = (c0 < 1) ? 1 : c0;
    c[1] = (c1 < 1) ? 1 : c1;
    q[0] = (q0 > c[0] - 1) ? c[0] - 1 : q0;
    q[1] = (q1 > c[1] - 1) ? c[1] - 1 : q1;
    for (int k = 0; k < 2; k++) need[k] = c[k] - q[k];
    t = L + a1 - p;
    j = 1;
    while (t + d <= H) begin
      expq[0].push_back(t + d);
      for (int k = 0; k < 2; k++) begin
        if (j == need[k]) begin
          expq[k+1].push_back(t + d);
          need[k] += c[k];
        end
      end
      t += a2;
      j++;
    end
  endtask

  task automatic seg(string t, int r1, int r2, int ps, int c0, int q0, int c1, int q1, bit rs, int len);
    int L;
    src_ratio = 8'(r1);
    src_phase = 8'(ps);
    ch_ratio  = {8'(c1), 8'(c0)};
    ch_phase  = {8'(q1), 8'(q0)};
    load = 1'b1;
    L = cyc + 1;
    plan(L, L + len, r1, r2, ps, c0, q0, c1, q1, rs);
    tag = t;
    @(posedge clk); #2;
    load = 1'b0;
    resync_on = rs;
    src_ratio = 8'(r2);
    repeat (len) begin @(posedge clk); #2; end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout, expected completion");
    finish_run();
  end

  initial begin
    int e;
    repeat (3) @(posedge clk);
    #2;
    src_phase = 8'd1;
    ch_phase  = 16'h0202;
    rst = 1'b0;
    e = cyc;
    checks++;
    if (src_en !== 1'b0 || ch_en !== 2'b00) begin
      errors++;
      $display("FAIL R4: actual src=%b ch=%b, expected 0 00", src_en, ch_en);
    end
    plan(e, e + 60, 2, 2, 0, 5, 0, 3, 0, 1'b0);
    mon_on = 1'b1;
    repeat (60) begin @(posedge clk); #2; end

    seg("R2 R5 R8", 4, 4, 1, 3, 2, 2, 0, 1'b0, 80);
    seg("R7 R8",    2, 2, 0, 5, 0, 3, 0, 1'b1, 70);
    seg("R1",       1, 1, 0, 1, 0, 0, 0, 1'b0, 20);
    seg("R3",       3, 3, 9, 4, 200, 2, 1, 1'b0, 50);
    seg("R6",       3, 5, 0, 2, 0, 3, 0, 1'b0, 80);
    seg("R5 R7",    1, 1, 0, 1, 0, 2, 0, 1'b1, 4);
    seg("R9",       2, 2, 1, 5, 4, 3, 1, 1'b0, 60);

    rst = 1'b1;
    repeat (4) begin @(posedge clk); #2; end
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      if (expq[i].size() > 0) begin
        errors++;
        $display("FAIL end out%0d: actual %0d pending, expected 0", i, expq[i].size());
      end
    end
    finish_run();
  end
endmodule